// File: doc/BRIEF.md
# Clock Manager Status Monitor

This block builds an 8-bit status word for a clock-management unit. It keeps a signed fine phase-shift count that moves one step per increment or decrement request. The count cannot pass a symmetric limit, and a flag marks when the count sits at that limit or a step past it is refused. The block also watches two clocks it does not own: the reference input clock and the synthesized output clock. For each one, a toggle flag in that clock's own domain is carried into the system clock domain. The clock is declared stopped when the synchronized flag holds still for a set number of system cycles.

Each status bit depends on how the unit is set up. The reference-stopped bit means something only when the feedback path is connected. The synthesized-stopped bit means something only while the frequency synthesizer is in use. When its condition is not met, a bit is held at zero. All outputs are registered in the system clock domain, and the unused upper bits always read zero.

Top module: `clkmgr_status_mon`

## Requirements
- R1: The status bit map is fixed: bit 0 is phase-shift overflow, bit 1 is reference clock stopped, bit 2 is synthesized clock stopped, and bits 7 down to 3 always read 0.
- R2: `ps_value` is a two's-complement 9-bit count. An increment strobe alone adds 1, a decrement strobe alone subtracts 1, and both together or neither leave it unchanged. The new value is visible on the edge after the strobe is sampled.
- R3: A step that would move the count above +255 or below -255 is refused. The count holds its value and the overflow bit becomes 1.
- R4: A step that lands the count exactly on +255 or -255 (every delay tap in use) sets the overflow bit.
- R5: A step that moves the count toward zero clears the overflow bit. Status bit 0 reflects a step two clock edges after the strobe is sampled.
- R6: With feedback connected, status bit 1 reads 1 once the reference clock has produced no edges for 16 system cycles plus the synchronizer latency. It reads 0 while the reference clock toggles.
- R7: With `fb_connected` low, status bit 1 reads 0 whatever the reference clock does.
- R8: With the synthesizer enabled, status bit 2 reads 1 once the synthesized clock has produced no edges for 16 system cycles plus the synchronizer latency. It reads 0 while that clock toggles.
- R9: With `synth_enabled` low, status bit 2 reads 0 whatever the synthesized clock does.
- R10: A synchronous reset forces the status word to 0 and `ps_value` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference input clock being monitored |
| fb_connected | input | 1 | Feedback path connected; enables status bit 1 |
| synth_enabled | input | 1 | Frequency synthesizer in use; enables status bit 2 |
| synth_clk | input | 1 | Synthesized output clock being monitored |
| ps_inc | input | 1 | Phase-shift increment strobe (system clock domain) |
| ps_dec | input | 1 | Phase-shift decrement strobe (system clock domain) |
| status | output | 8 | Registered status word |
| ps_value | output | 9 | Current signed phase-shift count |

## Verification
The hardest states to reach are the two ends of the shift range. Getting there takes 255 single steps in one direction, and the refused step and the clearing step then have to be applied at the limit. The bench walks the count across the whole range one strobe at a time and checks the count and the overflow bit after every step against an arithmetic model. It pushes past each limit and then comes back toward zero. A stopped clock is produced by freezing the bench's clock generators at their current level. The bench then goes through every combination of feedback, synthesizer enable and running or frozen clocks.

// File: rtl/clkmgr_status_pkg.sv
package clkmgr_status_pkg;
  localparam int STAT_W       = 8;
  localparam int BIT_OVF      = 0;
  localparam int BIT_REF_STOP = 1;
  localparam int BIT_SYN_STOP = 2;
  localparam int N_MON        = 2;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/clkmgr_ps_tracker.sv
module clkmgr_ps_tracker
  import clkmgr_status_pkg::*;
#(
  parameter int PS_W  = 9,
  parameter int LIMIT = 255
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inc,
  input  logic                   dec,
  output logic signed [PS_W-1:0] value,
  output logic                   ovf
);
  localparam logic signed [PS_W-1:0] LIM_POS = PS_W'(LIMIT);
  localparam logic signed [PS_W-1:0] LIM_NEG = -LIM_POS;
  localparam logic signed [PS_W-1:0] ONE     = PS_W'(1);

  step_e step;
  logic signed [PS_W-1:0] up_val;
  logic signed [PS_W-1:0] dn_val;

  always_comb begin
    if (inc && !dec)      step = STEP_UP;
    else if (dec && !inc) step = STEP_DOWN;
    else                  step = STEP_NONE;
    up_val = value + ONE;
    dn_val = value - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      ovf   <= 1'b0;
    end else begin
      case (step)
        STEP_UP: begin
          if (value == LIM_POS) begin
            ovf <= 1'b1;
          end else begin
            value <= up_val;
            if (value < 0)              ovf <= 1'b0;
            else if (up_val == LIM_POS) ovf <= 1'b1;
          end
        end
        STEP_DOWN: begin
          if (value == LIM_NEG) begin
            ovf <= 1'b1;
          end else begin
            value <= dn_val;
            if (value > 0)              ovf <= 1'b0;
            else if (dn_val == LIM_NEG) ovf <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkmgr_activity_det.sv
module clkmgr_activity_det #(
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  output logic stopped
);
  localparam int CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STALL_CYCLES - 1);

  logic                   tgl = 1'b0;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [CW-1:0]          cnt;

  always_ff @(posedge mon_clk) tgl <= ~tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      cnt     <= '0;
      stopped <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tgl};
      last_q <= sync_q[SYNC_STAGES-1];
      if (sync_q[SYNC_STAGES-1] != last_q) begin
        cnt     <= '0;
        stopped <= 1'b0;
      end else if (cnt == CNT_LAST) begin
        stopped <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/clkmgr_status_mon.sv
module clkmgr_status_mon
  import clkmgr_status_pkg::*;
#(
  parameter int PS_W         = 9,
  parameter int PS_LIMIT     = 255,
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_clk,
  input  logic                   fb_connected,
  input  logic                   synth_enabled,
  input  logic                   synth_clk,
  input  logic                   ps_inc,
  input  logic                   ps_dec,
  output logic [STAT_W-1:0]      status,
  output logic signed [PS_W-1:0] ps_value
);
  logic             ovf;
  logic [N_MON-1:0] mon_clks;
  logic [N_MON-1:0] mon_stop;
  logic [N_MON-1:0] mon_gate;
  logic [STAT_W-1:0] status_d;

  assign mon_clks = {synth_clk, ref_clk};
  assign mon_gate = {synth_enabled, fb_connected};

  clkmgr_ps_tracker #(.PS_W(PS_W), .LIMIT(PS_LIMIT)) u_ps (
    .clk(clk), .rst(rst), .inc(ps_inc), .dec(ps_dec),
    .value(ps_value), .ovf(ovf)
  );

  for (genvar g = 0; g < N_MON; g++) begin : g_mon
    clkmgr_activity_det #(
      .SYNC_STAGES(SYNC_STAGES), .STALL_CYCLES(STALL_CYCLES)
    ) u_det (
      .clk(clk), .rst(rst), .mon_clk(mon_clks[g]), .stopped(mon_stop[g])
    );
  end

  always_comb begin
    status_d               = '0;
    status_d[BIT_OVF]      = ovf;
    status_d[BIT_REF_STOP] = mon_stop[0] & mon_gate[0];
    status_d[BIT_SYN_STOP] = mon_stop[1] & mon_gate[1];
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_d;
  end
endmodule

// File: rtl/clkmgr_status_mon_chk.sv
module clkmgr_status_mon_chk #(
  parameter int PS_W     = 9,
  parameter int PS_LIMIT = 255
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   fb_connected,
  input logic                   synth_enabled,
  input logic                   ps_inc,
  input logic                   ps_dec,
  input logic [7:0]             status,
  input logic signed [PS_W-1:0] ps_value
);
  localparam logic signed [PS_W-1:0] LP = PS_W'(PS_LIMIT);
  localparam logic signed [PS_W-1:0] LN = -LP;

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    status[7:3] == 5'd0);
  assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ps_inc == ps_dec) |=> $stable(ps_value));
  assert_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (ps_value <= LP) && (ps_value >= LN));
  assert_refuse_up_R3: assert property (@(posedge clk) disable iff (rst)
    (ps_value == LP && ps_inc && !ps_dec) |=> (ps_value == LP));
  assert_refuse_down_R3: assert property (@(posedge clk) disable iff (rst)
    (ps_value == LN && ps_dec && !ps_inc) |=> (ps_value == LN));
  assert_clear_toward_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (ps_value > 0 && ps_dec && !ps_inc) |=> ##1 !status[0]);
  assert_fb_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !fb_connected |=> !status[1]);
  assert_syn_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !synth_enabled |=> !status[2]);
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (status == 8'd0 && ps_value == '0));
endmodule

bind clkmgr_status_mon clkmgr_status_mon_chk #(.PS_W(PS_W), .PS_LIMIT(PS_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .fb_connected(fb_connected), .synth_enabled(synth_enabled),
  .ps_inc(ps_inc), .ps_dec(ps_dec), .status(status), .ps_value(ps_value)
);

// File: tb/clkmgr_status_mon_tb.sv
module clkmgr_status_mon_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic ref_clk = 1'b0, synth_clk = 1'b0;
  logic fb_connected = 1'b0, synth_enabled = 1'b0;
  logic ps_inc = 1'b0, ps_dec = 1'b0;
  logic [7:0] status;
  logic signed [8:0] ps_value;
  logic ref_run = 1'b1, syn_run = 1'b1;
  int checks = 0, errors = 0;
  int exp_val = 0;
  int exp_ovf = 0;
  bit done = 1'b0;

  clkmgr_status_mon u_dut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .fb_connected(fb_connected),
    .synth_enabled(synth_enabled), .synth_clk(synth_clk),
    .ps_inc(ps_inc), .ps_dec(ps_dec), .status(status), .ps_value(ps_value)
  );

  always #4 clk = ~clk;
  initial forever begin #14; if (ref_run) ref_clk = ~ref_clk; end
  initial forever begin #10; if (syn_run) synth_clk = ~synth_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model step per R2..R5: R3 refuse at limit, R4 land on limit, R5 clear toward zero
  task automatic step(input bit up, input bit dn, input string req);
    @(negedge clk); ps_inc = up; ps_dec = dn;
    @(negedge clk); ps_inc = 1'b0; ps_dec = 1'b0;
    if (up && !dn) begin
      if (exp_val == 255) exp_ovf = 1;
      else begin
        if (exp_val < 0) exp_ovf = 0;
        exp_val++;
        if (exp_val == 255) exp_ovf = 1;
      end
    end else if (dn && !up) begin
      if (exp_val == -255) exp_ovf = 1;
      else begin
        if (exp_val > 0) exp_ovf = 0;
        exp_val--;
        if (exp_val == -255) exp_ovf = 1;
      end
    end
    @(negedge clk);
    chk(int'(ps_value) == exp_val, req, int'(ps_value), exp_val);
    chk(int'(status[0]) == exp_ovf, req, int'(status[0]), exp_ovf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 8'd0, "R10", int'(status), 0);
    chk(ps_value == 9'sd0, "R10", int'(ps_value), 0);

    // R2 / R4 / R3: walk to upper limit and beyond
    for (int i = 0; i < 258; i++) step(1'b1, 1'b0, "R2_R4_R3_up");
    step(1'b1, 1'b1, "R2_both");
    step(1'b0, 1'b1, "R5_clear_pos");
    step(1'b1, 1'b0, "R4_relimit");
    // walk to lower limit and beyond
    for (int i = 0; i < 513; i++) step(1'b0, 1'b1, "R2_R4_R3_down");
    step(1'b0, 1'b0, "R2_none");
    step(1'b1, 1'b0, "R5_clear_neg");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2_up_mid");

    // R10 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_val = 0; exp_ovf = 0;
    @(negedge clk);
    chk(ps_value == 9'sd0, "R10", int'(ps_value), 0);
    chk(status == 8'd0, "R10", int'(status), 0);

    // R6..R9: every combination of gating and clock activity
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      fb_connected = c[0]; synth_enabled = c[1]; ref_run = c[2]; syn_run = c[3];
      repeat (40) @(negedge clk);
      begin
        int e1, e2;
        e1 = (c[0] && !c[2]) ? 1 : 0;
        e2 = (c[1] && !c[3]) ? 1 : 0;
        chk(int'(status[1]) == e1, c[0] ? "R6" : "R7", int'(status[1]), e1);
        chk(int'(status[2]) == e2, c[1] ? "R8" : "R9", int'(status[2]), e2);
        chk(status[7:3] == 5'd0, "R1", int'(status[7:3]), 0);
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule